// File: doc/BRIEF.md
# Programmable Serial Transmit Engine

This block is the transmit half of a classic asynchronous serial port. A 16-bit clock divisor produces a tick at sixteen times the bit rate. A shift engine turns each accepted byte into a frame on a single output line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. A single 7-bit line-control word sets the word length, the stop count, the parity mode (even, odd or fixed) and a break override that holds the line low.

Bytes arrive on a valid/ready write port. A one-deep holding register sits in front of the shifter, and `wr_ready` is high exactly while that register is empty. The producer keeps `wr_valid` and `wr_data` steady until a clock edge sees both valid and ready high; no byte is ever dropped or overwritten. A waiting byte moves into the shifter on the first tick after the shifter goes idle, and the holding register then frees up again. Two status pins report the state of the block: `hold_empty` says the holding register is empty, and `line_idle` says that both the holding register and the shifter are empty.

When a frame starts, the shifter captures the frame-format fields. Changing those fields during a frame therefore affects only later frames. The break bit is the exception: it acts on the line at once. With a 1.8432 MHz reference clock, the divisor for a given baud rate is f/(16·baud) rounded to the nearest integer, so 9600 baud uses a divisor of 12.

Top module: `serial_tx_engine`

## Requirements
- R1: Every frame begins with one start bit at logic 0, then the data bits least significant first. `line_ctrl[1:0]` selects the word length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 bits. The frame format is captured when the frame starts.
- R2: `line_ctrl[2]` = 0 ends the frame with one stop bit at logic 1, and = 1 ends it with two.
- R3: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 0, a parity bit follows the data bits. It is computed over the active data bits only. With `line_ctrl[4]` = 1 the count of ones across data and parity is even; with `line_ctrl[4]` = 0 it is odd. With `line_ctrl[3]` = 0 no parity bit is sent.
- R4: With `line_ctrl[3]` = 1 and `line_ctrl[5]` = 1, the parity bit is the constant inverse of `line_ctrl[4]`.
- R5: While `line_ctrl[6]` = 1, `txd` is 0, whether the block is idle or in the middle of a frame. Clearing the bit gives the line back to the frame in progress.
- R6: The divisor is {`div_hi`,`div_lo`}. Each bit lasts exactly 16 × divisor clock cycles, so a frame of n bits keeps `line_idle` low for n × 16 × divisor cycles, counted from the falling edge of the start bit.
- R7: A divisor of 0 stops the tick. `txd` then stays high, and an accepted byte waits in the holding register (`hold_empty` = 0, `line_idle` = 0).
- R8: A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` equals `hold_empty`, goes low on the cycle after acceptance, and the accepted data stays unchanged until it moves to the shifter.
- R9: A full holding register moves into an idle shifter on the next tick, and `hold_empty` returns to 1 while the frame is still running. `line_idle` is 1 only when both the holding register and the shifter are empty.
- R10: After reset, `txd` = 1, `hold_empty` = 1, `wr_ready` = 1 and `line_idle` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_ctrl | input | 7 | Frame format: [1:0] length, [2] two stops, [3] parity on, [4] even, [5] fixed parity, [6] break |
| div_lo | input | 8 | Divisor low byte |
| div_hi | input | 8 | Divisor high byte |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | 8 | Byte to send |
| wr_ready | output | 1 | Holding register can accept a byte |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register empty |
| line_idle | output | 1 | Holding register and shifter both empty |

## Verification
The assertions check the following on every cycle:
- the shifter state changes only on a tick;
- a transfer into the shifter happens only when the shifter is idle, and is followed by a start bit;
- a byte held in the holding register stays stable;
- the divisor counter never passes the divisor;
- `txd` is frozen while the divisor is 0.

Only the bench scenarios can show the following:
- that the bit sequence on the line is correct for each word length, parity mode and stop count;
- that frame durations scale with the divisor;
- that break overrides a frame in progress;
- that two queued bytes go out back to back.

// File: rtl/txser_pkg.sv
package txser_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // field order matches the line-control bit positions [6:0]
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wsel;
  } line_cfg_t;

  // mask of the active data bits for a word-length code
  function automatic logic [BYTE_W-1:0] word_mask(input logic [1:0] wsel);
    logic [BYTE_W-1:0] all_ones;
    all_ones = '1;
    return all_ones >> (2'd3 - wsel);
  endfunction

endpackage

// File: rtl/txser_baud.sv
module txser_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic             run;

  assign run  = (divisor != '0);
  assign tick = run && (cnt >= divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  // R6: with a steady divisor the counter stays inside its period
  a_r6_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(divisor)) |-> (cnt < divisor));

endmodule

// File: rtl/txser_hold.sv
module txser_hold #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              tick,
  input  logic              shift_idle,
  output logic              load,
  output logic [BYTE_W-1:0] load_data
);

  logic              full;
  logic [BYTE_W-1:0] data_q;
  logic              accept;

  assign wr_ready  = !full;
  assign accept    = wr_valid && !full;
  assign load      = full && tick && shift_idle;
  assign load_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      data_q <= wr_data;
    end else if (load) begin
      full   <= 1'b0;
    end
  end

  // R8: a waiting byte is never overwritten
  a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !load) |=> $stable(data_q));

endmodule

// File: rtl/txser_shift.sv
module txser_shift
  import txser_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  line_cfg_t         cfg,
  output logic              idle,
  output logic              ser_bit
);

  localparam int unsigned PH_W  = $clog2(OVERSAMPLE);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

  tx_state_e         state;
  logic [PH_W-1:0]   phase;
  logic [IDX_W-1:0]  bit_idx;
  logic [IDX_W-1:0]  last_idx;
  logic              stop_idx;
  logic [BYTE_W-1:0] shreg;
  logic [1:0]        wsel_q;
  logic              par_en_q;
  logic              two_stop_q;
  logic              par_q;
  logic [BYTE_W-1:0] masked;
  logic              par_next;

  assign masked   = load_data & word_mask(cfg.wsel);
  assign par_next = cfg.stick ? ~cfg.even : (cfg.even ? ^masked : ~^masked);
  assign last_idx = IDX_W'(BYTE_W - 4) + IDX_W'(wsel_q);
  assign idle     = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: ser_bit = 1'b0;
      ST_DATA:  ser_bit = shreg[0];
      ST_PAR:   ser_bit = par_q;
      default:  ser_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      phase      <= '0;
      bit_idx    <= '0;
      stop_idx   <= 1'b0;
      shreg      <= '0;
      wsel_q     <= 2'd3;
      par_en_q   <= 1'b0;
      two_stop_q <= 1'b0;
      par_q      <= 1'b0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (load) begin
          state      <= ST_START;
          phase      <= '0;
          shreg      <= load_data;
          wsel_q     <= cfg.wsel;
          par_en_q   <= cfg.par_en;
          two_stop_q <= cfg.two_stop;
          par_q      <= par_next;
        end
      end else if (phase == PH_LAST) begin
        phase <= '0;
        case (state)
          ST_START: begin
            state   <= ST_DATA;
            bit_idx <= '0;
          end
          ST_DATA: begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + IDX_W'(1);
            if (bit_idx == last_idx) begin
              bit_idx  <= '0;
              stop_idx <= 1'b0;
              state    <= par_en_q ? ST_PAR : ST_STOP;
            end
          end
          ST_PAR: begin
            stop_idx <= 1'b0;
            state    <= ST_STOP;
          end
          ST_STOP: begin
            if (two_stop_q && !stop_idx) stop_idx <= 1'b1;
            else                         state    <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  // R6: the frame advances only on a tick
  a_r6_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state));

  // R9: a transfer from the holding register finds the shifter idle
  a_r9_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (state == ST_IDLE));

  // R1: a transfer always opens a frame with its start bit
  a_r1_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (state == ST_START));

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import txser_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        line_ctrl,
  input  logic [7:0]        div_lo,
  input  logic [7:0]        div_hi,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  output logic              txd,
  output logic              hold_empty,
  output logic              line_idle
);

  localparam int unsigned DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]  divisor;
  logic              tick;
  logic              load;
  logic [BYTE_W-1:0] load_data;
  logic              shift_idle;
  logic              ser_bit;
  line_cfg_t         cfg;

  assign divisor = {div_hi, div_lo};
  assign cfg     = line_cfg_t'(line_ctrl);

  txser_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (divisor),
    .tick    (tick)
  );

  txser_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .tick       (tick),
    .shift_idle (shift_idle),
    .load       (load),
    .load_data  (load_data)
  );

  txser_shift #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_data (load_data),
    .cfg       (cfg),
    .idle      (shift_idle),
    .ser_bit   (ser_bit)
  );

  assign hold_empty = wr_ready;
  assign line_idle  = wr_ready && shift_idle;
  assign txd        = cfg.brk ? 1'b0 : ser_bit;

  // R7: with no divisor and a steady control word the line is frozen
  a_r7_frozen_line: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0 && $past(divisor) == '0 && $stable(line_ctrl)) |-> $stable(txd));

endmodule

// File: tb/serial_tx_engine_test.sv
module serial_tx_engine_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] line_ctrl;
  logic [15:0] div;
  logic       wr_valid;
  logic [7:0] wr_data;
  logic       wr_ready, txd, hold_empty, line_idle;

  int nvec  = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  serial_tx_engine uut (
    .clk(clk), .rst_n(rst_n), .line_ctrl(line_ctrl),
    .div_lo(div[7:0]), .div_hi(div[15:8]),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .txd(txd), .hold_empty(hold_empty), .line_idle(line_idle)
  );

  // {line_ctrl, divisor, data}
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {7'h03, 16'd1,  8'hA5},   // R1 8 bits, no parity, 1 stop
    {7'h00, 16'd2,  8'h3F},   // R1 5 bits, upper bits dropped
    {7'h1B, 16'd1,  8'h07},   // R3 8 bits even parity
    {7'h0A, 16'd3,  8'h81},   // R3 7 bits odd parity over active bits
    {7'h07, 16'd1,  8'h5A},   // R2 two stop bits
    {7'h29, 16'd1,  8'h00},   // R4 fixed parity 1
    {7'h3D, 16'd2,  8'hFF},   // R4 fixed parity 0, R2 two stops
    {7'h03, 16'd12, 8'h4E}    // R6 9600 baud from 1.8432 MHz
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int build_frame(input logic [6:0] lc, input logic [7:0] d, output logic [15:0] f);
    int n;
    int nb;
    logic p;
    f = '1;
    n = 0;
    f[n] = 1'b0; n = n + 1;
    nb = int'(lc[1:0]) + 5;
    p = 1'b0;
    for (int i = 0; i < nb; i++) begin
      f[n] = d[i]; n = n + 1;
      p = p ^ d[i];
    end
    if (lc[3]) begin
      if (lc[5])      f[n] = ~lc[4];
      else if (lc[4]) f[n] = p;
      else            f[n] = ~p;
      n = n + 1;
    end
    f[n] = 1'b1; n = n + 1;
    if (lc[2]) begin f[n] = 1'b1; n = n + 1; end
    return n;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    wr_data  = b;
    wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rx_frame(input int d, input int n, output logic [15:0] got, output int span);
    got  = '1;
    span = 0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (8 * d) begin @(negedge clk); span++; end
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (16 * d) begin @(negedge clk); span++; end
      got[i] = txd;
    end
  endtask

  task automatic wait_idle(inout int span);
    while (!line_idle) begin @(negedge clk); span++; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] exp_f, got_f, got2;
    int n, span;

    rst_n = 1'b0; line_ctrl = 7'h03; div = 16'd1; wr_valid = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(txd === 1'b1,        "R10 txd",        32'(txd), 1);
    check(hold_empty === 1'b1, "R10 hold_empty", 32'(hold_empty), 1);
    check(wr_ready === 1'b1,   "R10 wr_ready",   32'(wr_ready), 1);
    check(line_idle === 1'b1,  "R10 line_idle",  32'(line_idle), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: bit sequence (R1..R4) and duration (R6)
    for (int v = 0; v < NV; v++) begin
      line_ctrl = VEC[v][30:24];
      div       = VEC[v][23:8];
      @(negedge clk);
      n = build_frame(VEC[v][30:24], VEC[v][7:0], exp_f);
      send_byte(VEC[v][7:0]);
      rx_frame(int'(VEC[v][23:8]), n, got_f, span);
      wait_idle(span);
      check(got_f == exp_f, "R1/R2/R3/R4 frame bits", 32'(got_f), 32'(exp_f));
      check(span == n * 16 * int'(VEC[v][23:8]), "R6 frame length", 32'(span),
            32'(n * 16 * int'(VEC[v][23:8])));
    end

    // R6: divisor for 9600 baud at 1.8432 MHz, rounded to nearest
    check((1843200 + 8 * 9600 - 1) / (16 * 9600) == int'(VEC[7][23:8]), "R6 divisor 12",
          32'(VEC[7][23:8]), 12);

    // R5: break while idle
    line_ctrl = 7'h43; #1;
    check(txd === 1'b0, "R5 break idle", 32'(txd), 0);
    @(negedge clk); line_ctrl = 7'h03; #1;
    check(txd === 1'b1, "R5 break released", 32'(txd), 1);

    // R5: break in the middle of a frame of ones
    div = 16'd4; @(negedge clk);
    send_byte(8'hFF);
    repeat (16 * 4 * 3) @(negedge clk);
    check(txd === 1'b1, "R1 data bit high", 32'(txd), 1);
    line_ctrl = 7'h43; #1;
    check(txd === 1'b0, "R5 break mid frame", 32'(txd), 0);
    @(negedge clk); line_ctrl = 7'h03; #1;
    check(txd === 1'b1, "R5 frame resumes", 32'(txd), 1);
    span = 0; wait_idle(span);

    // R7: zero divisor holds everything
    div = 16'd0; @(negedge clk);
    send_byte(8'h55);
    repeat (100) @(negedge clk);
    check(txd === 1'b1,        "R7 line high",   32'(txd), 1);
    check(hold_empty === 1'b0, "R7 byte waits",  32'(hold_empty), 0);
    check(line_idle === 1'b0,  "R7 not idle",    32'(line_idle), 0);
    div = 16'd2;
    n = build_frame(7'h03, 8'h55, exp_f);
    rx_frame(2, n, got_f, span);
    wait_idle(span);
    check(got_f == exp_f, "R7 frame after restart", 32'(got_f), 32'(exp_f));

    // R8/R9: two bytes queued back to back
    div = 16'd4; @(negedge clk);
    send_byte(8'hC3);
    check(hold_empty === 1'b0 && wr_ready === 1'b0, "R8 full after accept", 32'(hold_empty), 0);
    for (int k = 0; k < 8 && !hold_empty; k++) @(negedge clk);
    check(hold_empty === 1'b1, "R9 holding freed", 32'(hold_empty), 1);
    check(line_idle === 1'b0,  "R9 shifter busy",  32'(line_idle), 0);
    send_byte(8'h3C);
    check(hold_empty === 1'b0 && line_idle === 1'b0, "R9 both busy", 32'({hold_empty, line_idle}), 0);
    n = build_frame(7'h03, 8'hC3, exp_f);
    rx_frame(4, n, got_f, span);
    check(got_f == exp_f, "R8 first frame", 32'(got_f), 32'(exp_f));
    n = build_frame(7'h03, 8'h3C, exp_f);
    rx_frame(4, n, got2, span);
    wait_idle(span);
    check(got2 == exp_f, "R8 second frame", 32'(got2), 32'(exp_f));
    check(span == n * 16 * 4, "R6 second frame length", 32'(span), 32'(n * 64));

    finish_run();
  end

endmodule